// File: doc/BRIEF.md
# Character Overlay Video Mixer

This block draws a grid of text characters on top of a live pixel stream. The stream arrives as active video only: a pixel-valid strobe, a line-start marker and a frame-start marker, with 8 bits each of red, green and blue. The block counts pixels and lines itself and places each pixel inside or outside a rectangular text window. Inside the window it finds the character cell and the glyph row and column of the pixel, and reads that cell's 16-bit word from an internal character memory. The pixel then shows a palette foreground colour where the glyph is lit and a filtered background everywhere else. The mixed pixel leaves exactly two cycles after it entered.

Software sets the block up through a small 16-bit register port: mode, filter, enable, timing-source choice, window size in cells, and the window's top-left pixel position. A second write-only port fills the character memory. Each memory word holds a character code in its upper byte and a colour attribute in its lower byte. Glyph shapes come from a fixed synthetic pattern rather than a font.

Top module: `ovl_mixer`

## Requirements
- R1: Register word address 0 reads the version constant 102 and address 1 reads the read-only features word 0x3F1F (memory columns minus 1 in bits 13:8, memory rows minus 1 in bits 4:0). Address 2 (control) keeps only bits 10:8, 6, 4:3 and 1:0. Addresses 4 (scale), 5 (x position) and 6 (y position) keep all 16 bits. Every register reads back combinationally on regRdData.
- R2: Address 3 (size) holds columns minus 1 in bits 13:8 and rows minus 1 in bits 4:0. A column field above 52 is stored as 52 and a row field above 25 is stored as 25, and all other bits read as 0.
- R3: After reset, control, size, scale and both positions read 0 and outValid is low.
- R4: outValid follows pixValid by exactly two cycles. The output equals the input pixel from two cycles earlier when control bit 6 (enable) is 0, when mode (control bits 4:3) is 0 (passthrough), or when the pixel is outside the window.
- R5: In mode 3 (off), every valid output pixel is black (0,0,0).
- R6: Cells are 12 pixels by 18 lines. A pixel at (x,y) is in the window when xpos <= x < xpos+12*cols and ypos <= y < ypos+18*rows. Its cell word is at memory address cellRow*64+cellCol. Word bits 15:8 hold the code, bits 7:4 the foreground index and bits 3:0 the background index.
- R7: A glyph pixel at column gx (0..11) and row gy (0..17) inside its cell is lit when gx<8, gy<16 and code bit ((gx+gy) mod 8) is 1. Lit pixels in mode 1 (overlay) show the foreground colour.
- R8: Palette index i maps each channel (red = bit 2, green = bit 1, blue = bit 0) to 0xFF if set and bit 3 set, 0xAA if set and bit 3 clear, 0x55 if clear and bit 3 set, and 0x00 otherwise.
- R9: Unlit window pixels use control bits 1:0 as the filter. 0 gives the background palette colour, 1 the input pixel, 2 each input channel shifted right by one, and 3 floor((r+g+b)/3) on all three channels.
- R10: In mode 2 (auto), cells whose code is 0 pass the input pixel through, and all other cells behave as in mode 1.
- R11: Control bits 10:8 select the active area: 1 gives 720x400, 2 gives 1024x768, and any other value gives 640x480. Pixels at x or y beyond the active area pass through.
- R12: lineStart with a valid pixel sets x to 0 and advances y. frameStart sets y to 0. Cycles without pixValid leave the counters unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 3 | Register word address |
| regWrData | input | 16 | Register write data |
| regRdData | output | 16 | Register read data for regAddr |
| memWe | input | 1 | Character memory write strobe |
| memAddr | input | 11 | Character memory word address |
| memWrData | input | 16 | Character word (code high, attribute low) |
| pixValid | input | 1 | Active pixel present |
| lineStart | input | 1 | First pixel of a line |
| frameStart | input | 1 | First pixel of a frame |
| pixR | input | 8 | Input red |
| pixG | input | 8 | Input green |
| pixB | input | 8 | Input blue |
| outValid | output | 1 | Mixed pixel present |
| outR | output | 8 | Output red |
| outG | output | 8 | Output green |
| outB | output | 8 | Output blue |

## Verification
The hardest case to reach is a text window that lies partly past the active width, where one timing-source choice must clip it and another must show it. The bench places the window at x position 648 and drives lines 700 pixels long. It runs the same frame with the 640-wide and the 1024-wide source and expects passthrough in the first run and glyphs in the second. Idle gaps between lines check that the counters hold while no pixel is present.

// File: rtl/ovl_pkg.sv
package ovl_pkg;
  parameter int BASE_W   = 64;
  parameter int BASE_H   = 32;
  parameter int MEM_AW   = $clog2(BASE_W * BASE_H);
  parameter int CELL_W   = 12;
  parameter int CELL_H   = 18;
  parameter int MAX_COLS = 53;
  parameter int MAX_ROWS = 26;
  parameter int X_W      = 12;
  parameter int Y_W      = 11;

  typedef struct packed {
    logic              valid;
    logic              inWin;
    logic [MEM_AW-1:0] addr;
    logic [3:0]        glyphX;
    logic [4:0]        glyphY;
    logic [1:0]        filter;
    logic [1:0]        mode;
    logic              enable;
  } pixStrobe_t;

  function automatic logic [23:0] palColor(input logic [3:0] idx);
    logic [7:0] hi, lo;
    hi = idx[3] ? 8'hFF : 8'hAA;
    lo = idx[3] ? 8'h55 : 8'h00;
    return {idx[2] ? hi : lo, idx[1] ? hi : lo, idx[0] ? hi : lo};
  endfunction

  function automatic logic glyphOn(input logic [7:0] code, input logic [3:0] gx,
                                   input logic [4:0] gy);
    logic [2:0] bitSel;
    bitSel = gx[2:0] + gy[2:0];
    return (gx < 4'd8) && (gy < 5'd16) && code[bitSel];
  endfunction
endpackage

// File: rtl/ovl_ctrl.sv
module ovl_ctrl
  import ovl_pkg::*;
#(
  parameter int VERSION = 102
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWe,
  input  logic [2:0]  regAddr,
  input  logic [15:0] regWrData,
  output logic [15:0] regRdData,
  input  logic        pixValid,
  input  logic        lineStart,
  input  logic        frameStart,
  output pixStrobe_t  strobe,
  output logic [1:0]  ctrlMode,
  output logic        ctrlEnable,
  output logic [5:0]  sizeColsM1,
  output logic [4:0]  sizeRowsM1
);
  localparam logic [15:0] FEATURES = 16'(((BASE_W - 1) << 8) | (BASE_H - 1));
  localparam logic [5:0]  COL_LIM  = 6'(MAX_COLS - 1);
  localparam logic [4:0]  ROW_LIM  = 5'(MAX_ROWS - 1);

  logic [1:0]  filterF;
  logic [2:0]  syncF;
  logic [15:0] scaleReg, xPosReg, yPosReg;
  logic [X_W-1:0] xNext, curX;
  logic [Y_W-1:0] yCur, curY;
  logic [X_W-1:0] activeW;
  logic [Y_W-1:0] activeH;
  logic [16:0] relX, relY, winW, winH;
  logic inX, inY, inActive;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      filterF    <= '0;
      ctrlMode   <= '0;
      ctrlEnable <= 1'b0;
      syncF      <= '0;
      sizeColsM1 <= '0;
      sizeRowsM1 <= '0;
      scaleReg   <= '0;
      xPosReg    <= '0;
      yPosReg    <= '0;
    end else if (regWe) begin
      case (regAddr)
        3'd2: begin
          filterF    <= regWrData[1:0];
          ctrlMode   <= regWrData[4:3];
          ctrlEnable <= regWrData[6];
          syncF      <= regWrData[10:8];
        end
        3'd3: begin
          sizeColsM1 <= (regWrData[13:8] > COL_LIM) ? COL_LIM : regWrData[13:8];
          sizeRowsM1 <= (regWrData[4:0] > ROW_LIM) ? ROW_LIM : regWrData[4:0];
        end
        3'd4: scaleReg <= regWrData;
        3'd5: xPosReg  <= regWrData;
        3'd6: yPosReg  <= regWrData;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (regAddr)
      3'd0:    regRdData = 16'(VERSION);
      3'd1:    regRdData = FEATURES;
      3'd2:    regRdData = {5'b0, syncF, 1'b0, ctrlEnable, 1'b0, ctrlMode, 1'b0, filterF};
      3'd3:    regRdData = {2'b0, sizeColsM1, 3'b0, sizeRowsM1};
      3'd4:    regRdData = scaleReg;
      3'd5:    regRdData = xPosReg;
      3'd6:    regRdData = yPosReg;
      default: regRdData = '0;
    endcase
  end

  // Position of the current pixel
  always_comb begin
    curX = lineStart ? '0 : xNext;
    if (frameStart)     curY = '0;
    else if (lineStart) curY = yCur + 1'b1;
    else                curY = yCur;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      xNext <= '0;
      yCur  <= '0;
    end else if (pixValid) begin
      xNext <= curX + 1'b1;
      yCur  <= curY;
    end
  end

  always_comb begin
    case (syncF)
      3'd1:    begin activeW = X_W'(720);  activeH = Y_W'(400); end
      3'd2:    begin activeW = X_W'(1024); activeH = Y_W'(768); end
      default: begin activeW = X_W'(640);  activeH = Y_W'(480); end
    endcase
  end

  always_comb begin
    relX     = 17'(curX) - 17'(xPosReg);
    relY     = 17'(curY) - 17'(yPosReg);
    winW     = 17'(CELL_W) * (17'(sizeColsM1) + 17'd1);
    winH     = 17'(CELL_H) * (17'(sizeRowsM1) + 17'd1);
    inX      = (17'(curX) >= 17'(xPosReg)) && (relX < winW);
    inY      = (17'(curY) >= 17'(yPosReg)) && (relY < winH);
    inActive = (curX < activeW) && (curY < activeH);
  end

  always_comb begin
    strobe.valid  = pixValid;
    strobe.inWin  = pixValid && inX && inY && inActive;
    strobe.addr   = MEM_AW'(relY / 17'(CELL_H)) * MEM_AW'(BASE_W) + MEM_AW'(relX / 17'(CELL_W));
    strobe.glyphX = 4'(relX % 17'(CELL_W));
    strobe.glyphY = 5'(relY % 17'(CELL_H));
    strobe.filter = filterF;
    strobe.mode   = ctrlMode;
    strobe.enable = ctrlEnable;
  end
endmodule

// File: rtl/ovl_datapath.sv
module ovl_datapath
  import ovl_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  pixStrobe_t        strobe,
  input  logic [7:0]        pixR,
  input  logic [7:0]        pixG,
  input  logic [7:0]        pixB,
  input  logic              memWe,
  input  logic [MEM_AW-1:0] memAddr,
  input  logic [15:0]       memWrData,
  output logic              outValid,
  output logic [7:0]        outR,
  output logic [7:0]        outG,
  output logic [7:0]        outB
);
  localparam int DEPTH = BASE_W * BASE_H;

  logic [15:0] charMem [DEPTH];
  logic [15:0] rdWord;
  pixStrobe_t  s1;
  logic [23:0] s1Rgb, bgRgb, mixRgb;
  logic [9:0]  sum;
  logic [7:0]  gray, code;
  logic        lit;

  always_ff @(posedge clk) begin
    if (memWe) charMem[memAddr] <= memWrData;
    rdWord <= charMem[strobe.addr];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      s1    <= '0;
      s1Rgb <= '0;
    end else begin
      s1    <= strobe;
      s1Rgb <= {pixR, pixG, pixB};
    end
  end

  always_comb begin
    code = rdWord[15:8];
    lit  = glyphOn(code, s1.glyphX, s1.glyphY);
    sum  = 10'(s1Rgb[23:16]) + 10'(s1Rgb[15:8]) + 10'(s1Rgb[7:0]);
    gray = 8'(sum / 10'd3);
    case (s1.filter)
      2'd0:    bgRgb = palColor(rdWord[3:0]);
      2'd1:    bgRgb = s1Rgb;
      2'd2:    bgRgb = {1'b0, s1Rgb[23:17], 1'b0, s1Rgb[15:9], 1'b0, s1Rgb[7:1]};
      default: bgRgb = {gray, gray, gray};
    endcase
    if (s1.mode == 2'd3)
      mixRgb = '0;
    else if (!s1.enable || s1.mode == 2'd0 || !s1.inWin)
      mixRgb = s1Rgb;
    else if (s1.mode == 2'd2 && code == 8'd0)
      mixRgb = s1Rgb;
    else
      mixRgb = lit ? palColor(rdWord[7:4]) : bgRgb;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      {outR, outG, outB} <= '0;
    end else begin
      outValid <= s1.valid;
      {outR, outG, outB} <= s1.valid ? mixRgb : 24'd0;
    end
  end
endmodule

// File: rtl/ovl_mixer.sv
module ovl_mixer
  import ovl_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWe,
  input  logic [2:0]  regAddr,
  input  logic [15:0] regWrData,
  output logic [15:0] regRdData,
  input  logic        memWe,
  input  logic [10:0] memAddr,
  input  logic [15:0] memWrData,
  input  logic        pixValid,
  input  logic        lineStart,
  input  logic        frameStart,
  input  logic [7:0]  pixR,
  input  logic [7:0]  pixG,
  input  logic [7:0]  pixB,
  output logic        outValid,
  output logic [7:0]  outR,
  output logic [7:0]  outG,
  output logic [7:0]  outB
);
  pixStrobe_t strobe;
  logic [1:0] ctrlMode;
  logic       ctrlEnable;
  logic [5:0] sizeColsM1;
  logic [4:0] sizeRowsM1;

  ovl_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .pixValid(pixValid),
    .lineStart(lineStart), .frameStart(frameStart), .strobe(strobe),
    .ctrlMode(ctrlMode), .ctrlEnable(ctrlEnable),
    .sizeColsM1(sizeColsM1), .sizeRowsM1(sizeRowsM1)
  );

  ovl_datapath uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .pixR(pixR), .pixG(pixG),
    .pixB(pixB), .memWe(memWe), .memAddr(MEM_AW'(memAddr)),
    .memWrData(memWrData), .outValid(outValid), .outR(outR), .outG(outG),
    .outB(outB)
  );
endmodule

// File: rtl/ovl_mixer_chk.sv
module ovl_mixer_chk
  import ovl_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       pixValid,
  input logic [7:0] pixR,
  input logic [7:0] pixG,
  input logic [7:0] pixB,
  input logic       outValid,
  input logic [7:0] outR,
  input logic [7:0] outG,
  input logic [7:0] outB,
  input logic [1:0] ctrlMode,
  input logic       ctrlEnable,
  input logic [5:0] sizeColsM1,
  input logic [4:0] sizeRowsM1
);
  logic [1:0] sinceRst;
  always_ff @(posedge clk) begin
    if (!rstN) sinceRst <= '0;
    else if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
  end

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst == 2'd3) |-> (outValid == $past(pixValid, 2))); // R4

  AST_PASS_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst == 2'd3 && outValid && !$past(ctrlEnable, 2) && $past(ctrlMode, 2) != 2'd3)
      |-> ({outR, outG, outB} == $past({pixR, pixG, pixB}, 2))); // R4

  AST_OFF_BLACK: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst == 2'd3 && outValid && $past(ctrlMode, 2) == 2'd3)
      |-> ({outR, outG, outB} == 24'd0)); // R5

  AST_SIZE_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    (sizeColsM1 <= 6'(MAX_COLS - 1)) && (sizeRowsM1 <= 5'(MAX_ROWS - 1))); // R2
endmodule

bind ovl_mixer ovl_mixer_chk uChk (
  .clk(clk), .rstN(rstN), .pixValid(pixValid), .pixR(pixR), .pixG(pixG),
  .pixB(pixB), .outValid(outValid), .outR(outR), .outG(outG), .outB(outB),
  .ctrlMode(ctrlMode), .ctrlEnable(ctrlEnable), .sizeColsM1(sizeColsM1),
  .sizeRowsM1(sizeRowsM1)
);

// File: tb/tb_ovl_mixer.sv
`timescale 1ns/1ps
module tb_ovl_mixer;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWe = 1'b0;
  logic [2:0] regAddr = '0;
  logic [15:0] regWrData = '0, regRdData;
  logic memWe = 1'b0;
  logic [10:0] memAddr = '0;
  logic [15:0] memWrData = '0;
  logic pixValid = 1'b0, lineStart = 1'b0, frameStart = 1'b0;
  logic [7:0] pixR = '0, pixG = '0, pixB = '0;
  logic outValid;
  logic [7:0] outR, outG, outB;

  always #4 clk = ~clk;

  ovl_mixer dut (.*);

  int errors = 0, checks = 0;
  logic [15:0] shMem [2048];
  int mMode = 0, mFilt = 0, mEn = 0, mSync = 0, mCols = 1, mRows = 1, mXp = 0, mYp = 0;
  int seed = 0;
  logic pV0 = 0, pV1 = 0;
  logic [23:0] pE0 = '0, pE1 = '0;
  string pT0 = "", pT1 = "";

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [23:0] pal(input logic [3:0] i);
    logic [7:0] c [2];
    logic [23:0] r;
    c[1] = i[3] ? 8'hFF : 8'hAA;
    c[0] = i[3] ? 8'h55 : 8'h00;
    r = {c[i[2]], c[i[1]], c[i[0]]};
    return r;
  endfunction

  function automatic logic [23:0] model(input int x, input int y, input logic [23:0] rgb);
    int aw, ah, rx, ry, gx, gy, sum;
    logic [15:0] w;
    logic [7:0] code, g;
    aw = (mSync == 1) ? 720 : (mSync == 2) ? 1024 : 640;
    ah = (mSync == 1) ? 400 : (mSync == 2) ? 768 : 480;
    if (mMode == 3) return 24'd0;
    if (mEn == 0 || mMode == 0) return rgb;
    if (x >= aw || y >= ah || x < mXp || y < mYp) return rgb;
    rx = x - mXp; ry = y - mYp;
    if (rx >= 12 * mCols || ry >= 18 * mRows) return rgb;
    w = shMem[(ry / 18) * 64 + rx / 12];
    code = w[15:8];
    gx = rx % 12; gy = ry % 18;
    if (mMode == 2 && code == 0) return rgb;
    if (gx < 8 && gy < 16 && code[(gx + gy) % 8]) return pal(w[7:4]);
    case (mFilt)
      0: return pal(w[3:0]);
      1: return rgb;
      2: return {1'b0, rgb[23:17], 1'b0, rgb[15:9], 1'b0, rgb[7:1]};
      default: begin
        sum = int'(rgb[23:16]) + int'(rgb[15:8]) + int'(rgb[7:0]);
        g = 8'(sum / 3);
        return {g, g, g};
      end
    endcase
  endfunction

  // one cycle: check output of the pixel driven two steps ago, then drive
  task automatic step(input logic v, input logic ls, input logic fs,
                      input logic [23:0] rgb, input logic [23:0] exp, input string tag);
    @(negedge clk);
    if (pV1) check(outValid && {outR, outG, outB} == pE1, pT1, {7'b0, outValid, outR, outG, outB}, {8'h01, pE1});
    else check(!outValid, "R4 idle", {31'b0, outValid}, 32'd0);
    pV1 = pV0; pE1 = pE0; pT1 = pT0;
    pV0 = v; pE0 = exp; pT0 = tag;
    pixValid = v; lineStart = ls; frameStart = fs;
    {pixR, pixG, pixB} = rgb;
  endtask

  task automatic regWr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic regChk(input logic [2:0] a, input logic [15:0] exp, input string tag);
    @(negedge clk);
    regAddr = a;
    #1;
    check(regRdData == exp, tag, {16'b0, regRdData}, {16'b0, exp});
  endtask

  task automatic setCtrl(input int sync, input int en, input int mode, input int filt);
    mSync = sync; mEn = en; mMode = mode; mFilt = filt;
    regWr(3'd2, 16'((sync << 8) | (en << 6) | (mode << 3) | filt));
  endtask

  task automatic setWin(input int cols, input int rows, input int xp, input int yp);
    mCols = cols; mRows = rows; mXp = xp; mYp = yp;
    regWr(3'd3, 16'(((cols - 1) << 8) | (rows - 1)));
    regWr(3'd5, 16'(xp));
    regWr(3'd6, 16'(yp));
  endtask

  task automatic memWr(input int row, input int col, input logic [15:0] w);
    @(negedge clk);
    memWe = 1'b1; memAddr = 11'(row * 64 + col); memWrData = w;
    shMem[row * 64 + col] = w;
    @(negedge clk);
    memWe = 1'b0;
  endtask

  task automatic sendFrame(input int w, input int h, input int gap, input string tag);
    logic [23:0] rgb;
    for (int y = 0; y < h; y++) begin
      for (int x = 0; x < w; x++) begin
        rgb = {8'(x * 7 + y + seed), 8'((x * 3) ^ (y * 5) ^ seed), 8'(x + y * 11 + seed * 3)};
        step(1'b1, x == 0, x == 0 && y == 0, rgb, model(x, y, rgb), tag);
      end
      for (int g = 0; g < gap; g++) step(1'b0, 1'b0, 1'b0, 24'h5A5A5A, 24'd0, tag);
    end
    step(1'b0, 1'b0, 1'b0, 24'd0, 24'd0, tag);
    step(1'b0, 1'b0, 1'b0, 24'd0, 24'd0, tag);
    seed++;
  endtask

  task automatic fillCells();
    logic [7:0] codes [6] = '{8'hFF, 8'hA5, 8'h00, 8'h3C, 8'h81, 8'h7E};
    for (int r = 0; r < 2; r++)
      for (int c = 0; c < 3; c++)
        memWr(r, c, {codes[r * 3 + c], 4'(r * 5 + c * 3 + 9), 4'(c * 4 + r + 2)});
  endtask

  task automatic testReset();
    regChk(3'd2, 16'h0000, "R3 control");
    regChk(3'd3, 16'h0000, "R3 size");
    regChk(3'd4, 16'h0000, "R3 scale");
    regChk(3'd5, 16'h0000, "R3 xpos");
    regChk(3'd6, 16'h0000, "R3 ypos");
    check(!outValid, "R3 outValid", {31'b0, outValid}, 32'd0);
  endtask

  task automatic testRegs();
    regChk(3'd0, 16'd102, "R1 version");
    regChk(3'd1, 16'h3F1F, "R1 features");
    regWr(3'd1, 16'h0000);
    regChk(3'd1, 16'h3F1F, "R1 features read-only");
    regWr(3'd2, 16'hFFFF);
    regChk(3'd2, 16'h075B, "R1 control mask");
    regWr(3'd4, 16'hBEEF);
    regChk(3'd4, 16'hBEEF, "R1 scale");
    regWr(3'd5, 16'hF00D);
    regChk(3'd5, 16'hF00D, "R1 xpos");
    regWr(3'd6, 16'h1234);
    regChk(3'd6, 16'h1234, "R1 ypos");
    regWr(3'd3, 16'hFFFF);
    regChk(3'd3, 16'h3419, "R2 size clamp");
    regWr(3'd3, 16'h0A05);
    regChk(3'd3, 16'h0A05, "R2 size in range");
    regWr(3'd3, 16'h3419);
    regChk(3'd3, 16'h3419, "R2 size at limit");
  endtask

  task automatic testPass();
    setWin(3, 2, 4, 2);
    setCtrl(0, 0, 1, 1);
    sendFrame(44, 40, 0, "R4 disabled passthrough");
    setCtrl(0, 1, 0, 1);
    sendFrame(44, 40, 1, "R4 mode0 passthrough");
  endtask

  task automatic testOverlay();
    setCtrl(0, 1, 1, 1);
    sendFrame(44, 40, 2, "R6 R7 R8 overlay original");
  endtask

  task automatic testFilters();
    setCtrl(0, 1, 1, 0);
    sendFrame(44, 40, 0, "R9 filter palette bg");
    setCtrl(0, 1, 1, 2);
    sendFrame(44, 40, 0, "R9 filter darker");
    setCtrl(0, 1, 1, 3);
    sendFrame(44, 40, 0, "R9 filter gray");
  endtask

  task automatic testOff();
    setCtrl(0, 1, 3, 1);
    sendFrame(44, 40, 0, "R5 off black");
  endtask

  task automatic testAuto();
    setCtrl(0, 1, 2, 0);
    sendFrame(44, 40, 1, "R10 auto blank cells");
  endtask

  task automatic testSync();
    setWin(2, 1, 648, 0);
    setCtrl(0, 1, 1, 0);
    sendFrame(700, 3, 0, "R11 clipped at 640");
    setCtrl(2, 1, 1, 0);
    sendFrame(700, 3, 0, "R11 shown at 1024");
  endtask

  task automatic testCounters();
    setWin(2, 2, 1, 3);
    setCtrl(0, 1, 1, 3);
    sendFrame(30, 40, 5, "R12 counters with gaps");
    sendFrame(20, 38, 3, "R12 new frame restarts");
  endtask

  bit done = 0;
  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 2048; i++) shMem[i] = '0;
    repeat (4) @(negedge clk);
    testReset();
    rstN = 1'b1;
    testReset();
    testRegs();
    for (int i = 0; i < 4; i++) memWr(0, 40 + i, 16'h0000);
    fillCells();
    testPass();
    testOverlay();
    testFilters();
    testOff();
    testAuto();
    testSync();
    testCounters();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule